// File: doc/BRIEF.md
# Channel Status and User Bit Capture

This block sits behind a subframe decoder in a two-channel digital audio receiver. For every received frame the decoder pulses `frameValid` once. With that pulse it presents the channel-status bit and the user bit of each channel, and it flags the frame that carries the start-of-block marker. The block gathers these bits over a block of 192 frames into shadow storage. When the last frame of a block arrives, it copies the whole block at once into read-visible register banks. Each channel has six 32-bit channel-status words and six 32-bit user-data words.

The block pulses an event when a block starts and another when it ends. At each block end it also pulses a per-channel change event for every channel whose channel-status contents differ from the block held before. An interrupt controller outside the block consumes these pulses. Software reads the banks through a combinational word-address read port.

Top module: `chan_status_capture`

## Requirements
- R1: After reset, every event output is 0 and every mapped register reads 0.
- R2: Bit n of a block, counted from the marker frame (n = 0), appears in the channel-status word n/32 at bit n mod 32. Byte k of the block therefore sits in word k/4 at bits 8*(k mod 4). Channel-status word i of channel c is read at byte address 0x30 + 0x30*c + 4*i, for i from 0 to 5.
- R3: User-data word i of channel c is read at byte address 0x48 + 0x30*c + 4*i and uses the same bit ordering as R2.
- R4: `blockStartEvt` is high for exactly one cycle, the cycle after a frame strobe that carries the marker. `blockEndEvt` is high for exactly one cycle, the cycle after the strobe of the 192nd frame of a block.
- R5: The readable banks keep their previous contents while a block is being collected, and all of them change together on the block-end cycle.
- R6: The user-data banks of both channels are reloaded at every block end, whether or not the channel status changed.
- R7: `csChangeEvt[c]` pulses together with `blockEndEvt` only if channel c's new 192 channel-status bits differ from the stored ones. Bit 0 of `csChangeEvt` is channel 0. The first block after reset raises the event for both channels.
- R8: A marker that arrives before 192 frames of the current block have been counted discards the partial block, and counting restarts at frame 0. No block-end event occurs for the discarded part.
- R9: Frame strobes without a marker that arrive when no block is open (before the first marker, or after a block end) are ignored: no event fires and no register changes.
- R10: Reads of any address outside the mapped words, including misaligned addresses, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameValid | input | 1 | One-cycle strobe per received frame |
| blockMarker | input | 1 | Frame carries the start-of-block marker (qualified by frameValid) |
| csBitIn | input | NUM_CH | Channel-status bit of each channel for this frame |
| udBitIn | input | NUM_CH | User bit of each channel for this frame |
| rdAddr | input | ADDR_W | Byte address of the register word to read |
| rdData | output | 32 | Word at rdAddr, combinational |
| blockStartEvt | output | 1 | Block-start pulse |
| blockEndEvt | output | 1 | Block-end pulse |
| csChangeEvt | output | NUM_CH | Per-channel channel-status change pulse |

## Verification
The assertions watch properties that hold on every cycle:
- the frame index stays in range while a block is open;
- the start and end pulses only follow a qualifying frame strobe;
- stray frames outside a block raise no pulse;
- the readable banks hold still on every cycle except a commit;
- change pulses occur only on block-end cycles;
- the first commit after reset flags both channels.

Only the bench scenarios can show the rest:
- the exact bit-to-word placement across all 24 words;
- whether a change is reported for equal versus differing blocks per channel;
- that user data is refreshed without a status change;
- that an early marker moves the block end by restarting the count.

// File: rtl/csu_pkg.sv
package csu_pkg;
  parameter int IDX_W = 8;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic             commit;
  } ctrlStrobes_t;
endpackage

// File: rtl/csu_ctrl.sv
module csu_ctrl
  import csu_pkg::*;
#(
  parameter int FRAMES = 192
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameValid,
  input  logic         blockMarker,
  output ctrlStrobes_t strobes,
  output logic         blockStartEvt,
  output logic         blockEndEvt
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);

  logic             inBlock;
  logic [IDX_W-1:0] frameIdx;
  logic             startQ;
  logic             endQ;

  always_comb begin
    strobes.wrEn   = frameValid && (blockMarker || inBlock);
    strobes.wrIdx  = blockMarker ? '0 : frameIdx;
    strobes.commit = strobes.wrEn && (strobes.wrIdx == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inBlock  <= 1'b0;
      frameIdx <= '0;
      startQ   <= 1'b0;
      endQ     <= 1'b0;
    end else begin
      startQ <= frameValid && blockMarker;
      endQ   <= strobes.commit;
      if (frameValid) begin
        if (blockMarker) begin
          inBlock  <= 1'b1;
          frameIdx <= IDX_W'(1);
        end else if (inBlock) begin
          if (frameIdx == LAST) begin
            inBlock  <= 1'b0;
            frameIdx <= '0;
          end else begin
            frameIdx <= frameIdx + 1'b1;
          end
        end
      end
    end
  end

  assign blockStartEvt = startQ;
  assign blockEndEvt   = endQ;

  // R8: open block always has a non-zero index within the block length
  a_r8_idx_bound: assert property (@(posedge clk) disable iff (!rstN)
    inBlock |-> (frameIdx <= LAST && frameIdx != '0));
  // R4: end pulse only follows a frame strobe
  a_r4_end_after_frame: assert property (@(posedge clk) disable iff (!rstN)
    blockEndEvt |-> $past(frameValid));
  // R4: start pulse only follows a marked frame strobe
  a_r4_start_after_marker: assert property (@(posedge clk) disable iff (!rstN)
    blockStartEvt |-> $past(frameValid && blockMarker));
  // R9: stray frame outside a block raises nothing
  a_r9_stray_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && !blockMarker && !inBlock) |=> (!blockEndEvt && !blockStartEvt));
endmodule

// File: rtl/csu_datapath.sv
module csu_datapath
  import csu_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int FRAMES    = 192,
  parameter int ADDR_W    = 8,
  parameter int CS_BASE   = 'h30,
  parameter int UD_BASE   = 'h48,
  parameter int CH_STRIDE = 'h30
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [NUM_CH-1:0] csBitIn,
  input  logic [NUM_CH-1:0] udBitIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic [NUM_CH-1:0] csChangeEvt
);
  localparam int WORDS = FRAMES / 32;

  logic [NUM_CH-1:0][FRAMES-1:0] shadowCs, shadowUd;
  logic [NUM_CH-1:0][FRAMES-1:0] nextCs, nextUd;
  logic [NUM_CH-1:0][FRAMES-1:0] visCs, visUd;
  logic [NUM_CH-1:0]             chgQ;
  logic                          seenBlock;

  always_comb begin
    nextCs = shadowCs;
    nextUd = shadowUd;
    if (strobes.wrEn) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        nextCs[ch][strobes.wrIdx] = csBitIn[ch];
        nextUd[ch][strobes.wrIdx] = udBitIn[ch];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowCs  <= '0;
      shadowUd  <= '0;
      visCs     <= '0;
      visUd     <= '0;
      chgQ      <= '0;
      seenBlock <= 1'b0;
    end else begin
      shadowCs <= nextCs;
      shadowUd <= nextUd;
      chgQ     <= '0;
      if (strobes.commit) begin
        visCs     <= nextCs;
        visUd     <= nextUd;
        seenBlock <= 1'b1;
        for (int ch = 0; ch < NUM_CH; ch++)
          chgQ[ch] <= !seenBlock || (nextCs[ch] != visCs[ch]);
      end
    end
  end

  assign csChangeEvt = chgQ;

  always_comb begin
    rdData = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int w = 0; w < WORDS; w++) begin
        if (rdAddr == ADDR_W'(CS_BASE + ch * CH_STRIDE + w * 4))
          rdData = visCs[ch][w*32 +: 32];
        if (rdAddr == ADDR_W'(UD_BASE + ch * CH_STRIDE + w * 4))
          rdData = visUd[ch][w*32 +: 32];
      end
    end
  end

  // R5: visible banks move only on a commit
  a_r5_atomic_update: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> ($stable(visCs) && $stable(visUd)));
  // R7: first commit after reset flags every channel
  a_r7_first_block: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && !seenBlock) |=> (csChangeEvt == '1));
endmodule

// File: rtl/chan_status_capture.sv
module chan_status_capture
  import csu_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int FRAMES = 192,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameValid,
  input  logic              blockMarker,
  input  logic [NUM_CH-1:0] csBitIn,
  input  logic [NUM_CH-1:0] udBitIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic              blockStartEvt,
  output logic              blockEndEvt,
  output logic [NUM_CH-1:0] csChangeEvt
);
  ctrlStrobes_t strobes;

  csu_ctrl #(.FRAMES(FRAMES)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .frameValid    (frameValid),
    .blockMarker   (blockMarker),
    .strobes       (strobes),
    .blockStartEvt (blockStartEvt),
    .blockEndEvt   (blockEndEvt)
  );

  csu_datapath #(
    .NUM_CH (NUM_CH),
    .FRAMES (FRAMES),
    .ADDR_W (ADDR_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .csBitIn     (csBitIn),
    .udBitIn     (udBitIn),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .csChangeEvt (csChangeEvt)
  );

  // R7: change pulses only on block-end cycles
  a_r7_change_at_end: assert property (@(posedge clk) disable iff (!rstN)
    (|csChangeEvt) |-> blockEndEvt);
endmodule

// File: tb/chan_status_capture_bench.sv
`timescale 1ns/1ps
module chan_status_capture_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameValid = 1'b0;
  logic        blockMarker = 1'b0;
  logic [1:0]  csBitIn = '0;
  logic [1:0]  udBitIn = '0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        blockStartEvt, blockEndEvt;
  logic [1:0]  csChangeEvt;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  int expCs[2];
  int expUd[2];
  logic sEvt, eEvt;
  logic [1:0] cEvt;

  always #2.5 clk = ~clk;

  chan_status_capture u_chan_status_capture (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .blockMarker(blockMarker),
    .csBitIn(csBitIn), .udBitIn(udBitIn), .rdAddr(rdAddr), .rdData(rdData),
    .blockStartEvt(blockStartEvt), .blockEndEvt(blockEndEvt), .csChangeEvt(csChangeEvt)
  );

  function automatic logic bitOf(int seed, int ch, int n);
    int h;
    if (seed == 0) return 1'b0;
    h = n * n + seed * n * 5 + seed * seed * 3 + ch * 17 + n / 5 + seed * 29;
    return h[1] ^ h[3];
  endfunction

  function automatic logic [31:0] wordOf(int seed, int ch, int w);
    logic [31:0] r;
    for (int j = 0; j < 32; j++) r[j] = bitOf(seed, ch, w * 32 + j);
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic readWord(logic [7:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    rdAddr = a;
    #1;
    chk(rdData === exp, req, rdData, exp);
  endtask

  task automatic checkRegs(string req);
    for (int ch = 0; ch < 2; ch++)
      for (int w = 0; w < 6; w++) begin
        readWord(8'(8'h30 + ch * 8'h30 + w * 4), wordOf(expCs[ch], ch, w), req);
        readWord(8'(8'h48 + ch * 8'h30 + w * 4), wordOf(expUd[ch], ch, w), {req, "/R3"});
      end
  endtask

  task automatic sendFrame(logic mk, logic [1:0] cs, logic [1:0] ud, int gap);
    @(negedge clk);
    frameValid = 1'b1; blockMarker = mk; csBitIn = cs; udBitIn = ud;
    @(negedge clk);
    frameValid = 1'b0; blockMarker = 1'b0;
    sEvt = blockStartEvt; eEvt = blockEndEvt; cEvt = csChangeEvt;
    repeat (gap) @(negedge clk);
  endtask

  task automatic sendBlock(int c0, int c1, int u0, int u1, int nFr, int gap,
                           logic [1:0] expChg, bit useMk);
    bit full;
    full = useMk && nFr == 192;
    for (int n = 0; n < nFr; n++) begin
      sendFrame(useMk && n == 0, {bitOf(c1, 1, n), bitOf(c0, 0, n)},
                {bitOf(u1, 1, n), bitOf(u0, 0, n)}, gap);
      chk(sEvt === (useMk && n == 0), useMk ? "R4 start" : "R9 start", 32'(sEvt), 32'(useMk && n == 0));
      chk(eEvt === (full && n == 191), useMk ? "R4 end" : "R9 end", 32'(eEvt), 32'(full && n == 191));
      if (full && n == 191)
        chk(cEvt === expChg, "R7 change", 32'(cEvt), 32'(expChg));
      else
        chk(cEvt === 2'b00, "R7 quiet", 32'(cEvt), 32'h0);
      if (n == 100) checkRegs("R5");
    end
    if (full) begin
      expCs[0] = c0; expCs[1] = c1; expUd[0] = u0; expUd[1] = u1;
      checkRegs("R2");
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    expCs = '{0, 0}; expUd = '{0, 0};
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(blockStartEvt === 1'b0 && blockEndEvt === 1'b0 && csChangeEvt === 2'b00,
        "R1 events", {29'd0, blockStartEvt, blockEndEvt, 1'b0} | 32'(csChangeEvt), 32'h0);
    checkRegs("R1");
    // R9: frames before any marker
    sendBlock(5, 6, 7, 8, 10, 0, 2'b00, 1'b0);
    checkRegs("R9");
    // first block: both channels flagged
    sendBlock(1, 2, 3, 4, 192, 1, 2'b11, 1'b1);
    // R9: stray frames after block end
    sendBlock(11, 12, 13, 14, 5, 0, 2'b00, 1'b0);
    checkRegs("R9");
    // R6: same status, new user data, no change event
    sendBlock(1, 2, 5, 6, 192, 0, 2'b00, 1'b1);
    checkRegs("R6");
    // R7: only channel 1 status differs
    sendBlock(1, 7, 5, 6, 192, 2, 2'b10, 1'b1);
    // R7: only channel 0 status differs
    sendBlock(9, 7, 5, 6, 192, 0, 2'b01, 1'b1);
    // R8: partial block then early marker restarts counting
    sendBlock(8, 8, 8, 8, 50, 0, 2'b00, 1'b1);
    sendBlock(9, 7, 10, 12, 192, 0, 2'b00, 1'b1);
    checkRegs("R8");
    // R10: unmapped and misaligned addresses
    readWord(8'h00, 32'h0, "R10");
    readWord(8'h2C, 32'h0, "R10");
    readWord(8'h31, 32'h0, "R10");
    readWord(8'h90, 32'h0, "R10");
    readWord(8'hFC, 32'h0, "R10");
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule